// File: doc/BRIEF.md
# Acknowledged Serial Link Protocol Engine

This block runs a half-duplex, point-to-point link layer over a byte-wide UART. It frames messages with escape-based control characters and waits for an acknowledge at each step. When the local user asks it to send, it first asks the partner for a connection with an STX byte. It sends the payload only after the partner answers DLE. The frame closes with DLE ETX and a one-byte XOR check. The partner's final DLE makes the transfer good. A NAK, a stray byte or a missing reply triggers a bounded retry.

When the partner starts a transfer, the block accepts it with DLE. It strips the escape doubling, delivers the payload bytes as they arrive and checks the XOR byte at the end. It answers DLE if the check matches and NAK if it does not. The payload is delivered before the check byte is known, so the user discards it when `rcv_err_o` pulses. Three watchdog windows guard the exchange: a per-character gap, the wait for an acknowledge and the length of a whole incoming message. All three are counted in pulses of `tick_i`.

The transmit payload is read by index from a buffer that the user holds. A retry therefore replays the same bytes without internal storage.

Top module: `link3964`

## Requirements
- R1: After `snd_start_i` is taken while the block is idle, the first byte sent is STX (0x02). No payload byte is sent until a DLE (0x10) has been received.
- R2: In the outgoing frame, every payload byte equal to DLE is sent twice. The frame ends with DLE, ETX (0x03) and one check byte. An empty payload sends only DLE, ETX and the check byte.
- R3: The check byte is the XOR of every byte sent after STX, counting doubled DLEs and the closing DLE and ETX.
- R4: If the byte received after STX is not DLE (a NAK 0x15 or any other byte), or no byte arrives within the acknowledge window, the connection attempt fails. STX is then sent again, up to `cfg_conn_retry_i` extra times. After that `snd_fail_o` pulses with `snd_fail_code_o` = 1.
- R5: After the check byte, a received DLE pulses `snd_done_o`. Any other byte, or silence for the acknowledge window, restarts the whole transfer from STX, up to `cfg_blk_retry_i` extra times. After that `snd_fail_o` pulses with code 2.
- R6: When idle with `rcv_en_i` high, a received STX is answered with DLE. The following payload is delivered on `rcv_valid_o`/`rcv_data_o`, and a doubled DLE is delivered as one DLE byte.
- R7: After DLE ETX, a check byte that matches the XOR of the received bytes after STX is answered with DLE and pulses `rcv_done_o`. A mismatch is answered with NAK and pulses `rcv_err_o`.
- R8: When idle, a received byte that is neither STX nor NAK is answered with NAK. An STX that arrives while `rcv_en_i` is low is also answered with NAK. A received NAK gets no reply.
- R9: During an incoming message, a gap between bytes longer than the character window aborts it with NAK and a `rcv_err_o` pulse. The block then waits for a new STX.
- R10: An incoming message still unfinished when the block window runs out is aborted with NAK and a `rcv_err_o` pulse.
- R11: A 256th payload byte in one incoming message aborts it with NAK and a `rcv_err_o` pulse. Only 255 bytes are delivered.
- R12: All windows count `tick_i` pulses. A configured window of 0 selects 200 (character), 500 (acknowledge) or 10000 (block) ticks. A connection retry count of 0 selects 3.
- R13: While `utx_valid_o` is high and `utx_ready_i` is low, `utx_valid_o` and `utx_data_o` stay unchanged.
- R14: `snd_done_o` and `snd_fail_o` never pulse together, and neither do `rcv_done_o` and `rcv_err_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Timebase pulse that advances all windows |
| cfg_char_to_i | input | 16 | Character gap window in ticks, 0 selects the default |
| cfg_ack_to_i | input | 16 | Acknowledge window in ticks, 0 selects the default |
| cfg_blk_to_i | input | 16 | Whole-message window in ticks, 0 selects the default |
| cfg_conn_retry_i | input | 4 | Extra connection attempts, 0 selects the default |
| cfg_blk_retry_i | input | 4 | Extra block attempts |
| snd_start_i | input | 1 | Start a transfer (taken only while idle) |
| snd_len_i | input | 8 | Payload length in bytes, 0 to 255 |
| snd_idx_o | output | 8 | Index of the payload byte wanted |
| snd_data_i | input | 8 | Payload byte at `snd_idx_o` |
| snd_done_o | output | 1 | Transfer acknowledged (pulse) |
| snd_fail_o | output | 1 | Transfer abandoned (pulse) |
| snd_fail_code_o | output | 2 | 1 = connection failed, 2 = block failed |
| rcv_en_i | input | 1 | Ready to accept incoming messages |
| rcv_valid_o | output | 1 | Received payload byte valid (pulse) |
| rcv_data_o | output | 8 | Received payload byte |
| rcv_done_o | output | 1 | Incoming message good (pulse) |
| rcv_err_o | output | 1 | Incoming message rejected (pulse) |
| busy_o | output | 1 | A transfer in either direction is in progress |
| utx_valid_o | output | 1 | Byte to the UART valid |
| utx_data_o | output | 8 | Byte to the UART |
| utx_ready_i | input | 1 | UART takes the byte |
| urx_valid_i | input | 1 | Byte from the UART valid |
| urx_data_i | input | 8 | Byte from the UART |

## Verification
Outgoing frames are tried with payloads that hold an embedded DLE, a single plain byte and no bytes at all. This separates correct stuffing and check-byte coverage from a frame that skips the doubling or leaves the closing pair out of the XOR. The partner's answers to the active side cover the good case, a NAK, a stray byte and silence. Silence and a stray byte exercise the retry counters and the two failure codes. Both the default window and a slowed `tick_i` are measured to show that windows count ticks rather than clocks. Incoming messages are tried good and with a corrupted check byte. They are also tried with a stalled stream, a slow stream that outlives the block window, and an overlong stream. Each of these tells one abort path from another, and each is set against the no-reply rule for a received NAK.

// File: rtl/link3964_pkg.sv
package link3964_pkg;
  localparam logic [7:0] C_STX = 8'h02;
  localparam logic [7:0] C_ETX = 8'h03;
  localparam logic [7:0] C_DLE = 8'h10;
  localparam logic [7:0] C_NAK = 8'h15;
  localparam int unsigned MAX_PAY = 255;

  typedef enum logic [3:0] {
    T_IDLE, T_STX, T_WCON, T_DATA, T_DUP, T_EDLE, T_ETX, T_BCC, T_WACK
  } tx_st_e;

  typedef enum logic [2:0] {
    R_IDLE, R_REPLY, R_DATA, R_ESC, R_BCC
  } rx_st_e;
endpackage

// File: rtl/link_timer.sv
module link_timer #(
  parameter int TW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          clr_i,
  input  logic [TW-1:0] limit_i,
  output logic          expired_o
);
  logic [TW-1:0] cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt <= '0;
    else if (clr_i)                   cnt <= '0;
    else if (tick_i && cnt < limit_i) cnt <= cnt + 1'b1;
  end

  assign expired_o = !clr_i && (cnt >= limit_i);
endmodule

// File: rtl/link_tx.sv
module link_tx
  import link3964_pkg::*;
#(
  parameter int TW = 16,
  parameter int RW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          start_i,
  input  logic [7:0]    len_i,
  input  logic [7:0]    data_i,
  output logic [7:0]    idx_o,
  input  logic [TW-1:0] ack_to_i,
  input  logic [RW-1:0] conn_retry_i,
  input  logic [RW-1:0] blk_retry_i,
  input  logic          rx_valid_i,
  input  logic [7:0]    rx_data_i,
  output logic          tx_valid_o,
  output logic [7:0]    tx_data_o,
  input  logic          tx_ready_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          fail_o,
  output logic [1:0]    fail_code_o
);
  tx_st_e        st;
  logic [7:0]    idx, len_q, bcc;
  logic [RW-1:0] ccnt, bcnt;
  logic          to_exp, hs, last;

  link_timer #(.TW(TW)) u_ack (
    .clk_i, .rst_ni, .tick_i,
    .clr_i(!(st == T_WCON || st == T_WACK)),
    .limit_i(ack_to_i), .expired_o(to_exp)
  );

  always_comb begin
    tx_valid_o = 1'b1;
    unique case (st)
      T_STX:         tx_data_o = C_STX;
      T_DATA:        tx_data_o = data_i;
      T_DUP, T_EDLE: tx_data_o = C_DLE;
      T_ETX:         tx_data_o = C_ETX;
      T_BCC:         tx_data_o = bcc;
      default: begin tx_valid_o = 1'b0; tx_data_o = '0; end
    endcase
  end

  assign hs     = tx_valid_o && tx_ready_i;
  assign last   = (idx == len_q - 8'd1);
  assign idx_o  = idx;
  assign busy_o = (st != T_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st <= T_IDLE; idx <= '0; len_q <= '0; bcc <= '0;
      ccnt <= '0; bcnt <= '0;
      done_o <= 1'b0; fail_o <= 1'b0; fail_code_o <= '0;
    end else begin
      done_o <= 1'b0;
      fail_o <= 1'b0;
      case (st)
        T_IDLE: if (start_i) begin
          len_q <= len_i; ccnt <= '0; bcnt <= '0; st <= T_STX;
        end
        T_STX: if (hs) st <= T_WCON;
        T_WCON:
          if (rx_valid_i && rx_data_i == C_DLE) begin
            idx <= '0; bcc <= '0;
            st  <= (len_q == 8'd0) ? T_EDLE : T_DATA;
          end else if (rx_valid_i || to_exp) begin
            if (ccnt < conn_retry_i) begin
              ccnt <= ccnt + 1'b1; st <= T_STX;
            end else begin
              fail_o <= 1'b1; fail_code_o <= 2'd1; st <= T_IDLE;
            end
          end
        T_DATA, T_DUP: if (hs) begin
          bcc <= bcc ^ tx_data_o;
          if (st == T_DATA && tx_data_o == C_DLE) st <= T_DUP;
          else if (last) st <= T_EDLE;
          else begin idx <= idx + 8'd1; st <= T_DATA; end
        end
        T_EDLE: if (hs) begin bcc <= bcc ^ C_DLE; st <= T_ETX; end
        T_ETX:  if (hs) begin bcc <= bcc ^ C_ETX; st <= T_BCC; end
        T_BCC:  if (hs) st <= T_WACK;
        T_WACK:
          if (rx_valid_i && rx_data_i == C_DLE) begin
            done_o <= 1'b1; st <= T_IDLE;
          end else if (rx_valid_i || to_exp) begin
            if (bcnt < blk_retry_i) begin
              bcnt <= bcnt + 1'b1; ccnt <= '0; st <= T_STX;
            end else begin
              fail_o <= 1'b1; fail_code_o <= 2'd2; st <= T_IDLE;
            end
          end
        default: st <= T_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/link_rx.sv
module link_rx
  import link3964_pkg::*;
#(
  parameter int TW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          en_i,
  input  logic          rx_valid_i,
  input  logic [7:0]    rx_data_i,
  input  logic [TW-1:0] char_to_i,
  input  logic [TW-1:0] blk_to_i,
  output logic          tx_valid_o,
  output logic [7:0]    tx_data_o,
  input  logic          tx_ready_i,
  output logic          busy_o,
  output logic          out_valid_o,
  output logic [7:0]    out_data_o,
  output logic          done_o,
  output logic          err_o
);
  rx_st_e     st, nxt;
  logic [7:0] rep, bcc, cnt;
  logic       in_msg, c_exp, b_exp;

  assign in_msg = (st == R_DATA) || (st == R_ESC) || (st == R_BCC);

  link_timer #(.TW(TW)) u_char (
    .clk_i, .rst_ni, .tick_i,
    .clr_i(!in_msg || rx_valid_i), .limit_i(char_to_i), .expired_o(c_exp)
  );

  link_timer #(.TW(TW)) u_blk (
    .clk_i, .rst_ni, .tick_i,
    .clr_i(!in_msg), .limit_i(blk_to_i), .expired_o(b_exp)
  );

  assign tx_valid_o = (st == R_REPLY);
  assign tx_data_o  = rep;
  assign busy_o     = (st != R_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st <= R_IDLE; nxt <= R_IDLE; rep <= '0; bcc <= '0; cnt <= '0;
      out_valid_o <= 1'b0; out_data_o <= '0; done_o <= 1'b0; err_o <= 1'b0;
    end else begin
      out_valid_o <= 1'b0;
      done_o      <= 1'b0;
      err_o       <= 1'b0;
      if (in_msg && (c_exp || b_exp)) begin
        rep <= C_NAK; nxt <= R_IDLE; st <= R_REPLY; err_o <= 1'b1;
      end else begin
        case (st)
          R_IDLE: if (rx_valid_i) begin
            if (rx_data_i == C_STX && en_i) begin
              rep <= C_DLE; nxt <= R_DATA; bcc <= '0; cnt <= '0; st <= R_REPLY;
            end else if (rx_data_i != C_NAK) begin
              rep <= C_NAK; nxt <= R_IDLE; st <= R_REPLY;
            end
          end
          R_REPLY: if (tx_ready_i) st <= nxt;
          R_DATA, R_ESC: if (rx_valid_i) begin
            bcc <= bcc ^ rx_data_i;
            if (st == R_DATA && rx_data_i == C_DLE) st <= R_ESC;
            else if (st == R_ESC && rx_data_i == C_ETX) st <= R_BCC;
            else if ((st == R_ESC && rx_data_i != C_DLE) || cnt == 8'(MAX_PAY)) begin
              rep <= C_NAK; nxt <= R_IDLE; st <= R_REPLY; err_o <= 1'b1;
            end else begin
              out_valid_o <= 1'b1; out_data_o <= rx_data_i;
              cnt <= cnt + 8'd1; st <= R_DATA;
            end
          end
          R_BCC: if (rx_valid_i) begin
            nxt <= R_IDLE; st <= R_REPLY;
            if (rx_data_i == bcc) begin rep <= C_DLE; done_o <= 1'b1; end
            else begin rep <= C_NAK; err_o <= 1'b1; end
          end
          default: st <= R_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/link3964.sv
module link3964
  import link3964_pkg::*;
#(
  parameter int TW       = 16,
  parameter int RW       = 4,
  parameter int DEF_CHAR = 200,
  parameter int DEF_ACK  = 500,
  parameter int DEF_BLK  = 10000,
  parameter int DEF_CONN = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic [TW-1:0] cfg_char_to_i,
  input  logic [TW-1:0] cfg_ack_to_i,
  input  logic [TW-1:0] cfg_blk_to_i,
  input  logic [RW-1:0] cfg_conn_retry_i,
  input  logic [RW-1:0] cfg_blk_retry_i,
  input  logic          snd_start_i,
  input  logic [7:0]    snd_len_i,
  output logic [7:0]    snd_idx_o,
  input  logic [7:0]    snd_data_i,
  output logic          snd_done_o,
  output logic          snd_fail_o,
  output logic [1:0]    snd_fail_code_o,
  input  logic          rcv_en_i,
  output logic          rcv_valid_o,
  output logic [7:0]    rcv_data_o,
  output logic          rcv_done_o,
  output logic          rcv_err_o,
  output logic          busy_o,
  output logic          utx_valid_o,
  output logic [7:0]    utx_data_o,
  input  logic          utx_ready_i,
  input  logic          urx_valid_i,
  input  logic [7:0]    urx_data_i
);
  logic [TW-1:0] char_eff, ack_eff, blk_eff;
  logic [RW-1:0] conn_eff;
  logic          tx_busy, rx_busy, tx_go;
  logic          tx_v, rx_v;
  logic [7:0]    tx_d, rx_d;

  assign char_eff = (cfg_char_to_i == '0) ? TW'(DEF_CHAR) : cfg_char_to_i;
  assign ack_eff  = (cfg_ack_to_i  == '0) ? TW'(DEF_ACK)  : cfg_ack_to_i;
  assign blk_eff  = (cfg_blk_to_i  == '0) ? TW'(DEF_BLK)  : cfg_blk_to_i;
  assign conn_eff = (cfg_conn_retry_i == '0) ? RW'(DEF_CONN) : cfg_conn_retry_i;

  // half duplex: a local start only while the passive side is idle
  assign tx_go = snd_start_i && !rx_busy;

  link_tx #(.TW(TW), .RW(RW)) u_tx (
    .clk_i, .rst_ni, .tick_i,
    .start_i(tx_go), .len_i(snd_len_i), .data_i(snd_data_i), .idx_o(snd_idx_o),
    .ack_to_i(ack_eff), .conn_retry_i(conn_eff), .blk_retry_i(cfg_blk_retry_i),
    .rx_valid_i(urx_valid_i && tx_busy), .rx_data_i(urx_data_i),
    .tx_valid_o(tx_v), .tx_data_o(tx_d), .tx_ready_i(utx_ready_i && tx_busy),
    .busy_o(tx_busy), .done_o(snd_done_o), .fail_o(snd_fail_o),
    .fail_code_o(snd_fail_code_o)
  );

  link_rx #(.TW(TW)) u_rx (
    .clk_i, .rst_ni, .tick_i, .en_i(rcv_en_i),
    .rx_valid_i(urx_valid_i && !tx_busy && !tx_go), .rx_data_i(urx_data_i),
    .char_to_i(char_eff), .blk_to_i(blk_eff),
    .tx_valid_o(rx_v), .tx_data_o(rx_d), .tx_ready_i(utx_ready_i && !tx_busy),
    .busy_o(rx_busy), .out_valid_o(rcv_valid_o), .out_data_o(rcv_data_o),
    .done_o(rcv_done_o), .err_o(rcv_err_o)
  );

  assign utx_valid_o = tx_busy ? tx_v : rx_v;
  assign utx_data_o  = tx_busy ? tx_d : rx_d;
  assign busy_o      = tx_busy || rx_busy;
endmodule

// File: rtl/link3964_chk.sv
module link3964_chk
  import link3964_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       snd_start_i,
  input logic       busy_o,
  input logic       utx_valid_o,
  input logic [7:0] utx_data_o,
  input logic       utx_ready_i,
  input logic       snd_done_o,
  input logic       snd_fail_o,
  input logic [1:0] snd_fail_code_o,
  input logic       rcv_done_o,
  input logic       rcv_err_o
);
  p_stx_first_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snd_start_i && !busy_o |=> utx_valid_o && utx_data_o == C_STX);

  p_fail_code_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snd_fail_o |-> snd_fail_code_o != 2'd0);

  p_ack_good_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rcv_done_o |-> utx_valid_o && utx_data_o == C_DLE);

  p_nak_abort_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rcv_err_o |-> utx_valid_o && utx_data_o == C_NAK);

  p_hold_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    utx_valid_o && !utx_ready_i |=> utx_valid_o && $stable(utx_data_o));

  p_snd_excl_r14: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(snd_done_o && snd_fail_o));

  p_rcv_excl_r14: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rcv_done_o && rcv_err_o));
endmodule

bind link3964 link3964_chk u_chk (.*);

// File: tb/tb_link3964.sv
`timescale 1ns/1ps
module tb_link3964;
  import link3964_pkg::*;

  logic        clk = 1'b0, rst_n = 1'b0, tick = 1'b0;
  logic [15:0] cfg_char = 16'd20, cfg_ack = 16'd30, cfg_blk = 16'd0;
  logic [3:0]  cfg_conn = 4'd2, cfg_blkr = 4'd1;
  logic        snd_start = 1'b0, rcv_en = 1'b1, utx_ready = 1'b1, urx_valid = 1'b0;
  logic [7:0]  snd_len = '0, urx_data = '0;
  logic [7:0]  snd_idx, snd_data, rcv_data, utx_data;
  logic        snd_done, snd_fail, rcv_valid, rcv_done, rcv_err, busy, utx_valid;
  logic [1:0]  fail_code;
  logic [7:0]  sbuf [256];

  assign snd_data = sbuf[snd_idx];
  always #5 clk = ~clk;

  link3964 dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick),
    .cfg_char_to_i(cfg_char), .cfg_ack_to_i(cfg_ack), .cfg_blk_to_i(cfg_blk),
    .cfg_conn_retry_i(cfg_conn), .cfg_blk_retry_i(cfg_blkr),
    .snd_start_i(snd_start), .snd_len_i(snd_len), .snd_idx_o(snd_idx),
    .snd_data_i(snd_data), .snd_done_o(snd_done), .snd_fail_o(snd_fail),
    .snd_fail_code_o(fail_code), .rcv_en_i(rcv_en), .rcv_valid_o(rcv_valid),
    .rcv_data_o(rcv_data), .rcv_done_o(rcv_done), .rcv_err_o(rcv_err),
    .busy_o(busy), .utx_valid_o(utx_valid), .utx_data_o(utx_data),
    .utx_ready_i(utx_ready), .urx_valid_i(urx_valid), .urx_data_i(urx_data)
  );

  logic [7:0] exp_tx[$], exp_rx[$];
  int n_chk = 0, n_fail = 0, cyc = 0, tick_div = 1;
  int tx_seen = 0, done_seen = 0, fail_seen = 0, rdone_seen = 0, rerr_seen = 0;
  logic [1:0] last_code = '0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    tick <= (cyc % tick_div) == 0;
  end

  // monitor: pops expected items as the design produces them
  always @(negedge clk) if (rst_n) begin
    if (utx_valid && utx_ready) begin
      tx_seen++;
      if (exp_tx.size() == 0) check(0, "R2", "unexpected tx byte", utx_data, 0);
      else begin
        automatic logic [7:0] e = exp_tx.pop_front();
        check(utx_data == e, "R2", "tx byte", utx_data, e);
      end
    end
    if (rcv_valid) begin
      if (exp_rx.size() == 0) check(0, "R6", "unexpected rx payload", rcv_data, 0);
      else begin
        automatic logic [7:0] e = exp_rx.pop_front();
        check(rcv_data == e, "R6", "rx payload", rcv_data, e);
      end
    end
    if (snd_done || snd_fail) check(!(snd_done && snd_fail), "R14", "done/fail", 1, 0);
    if (rcv_done || rcv_err) check(!(rcv_done && rcv_err), "R14", "rdone/rerr", 1, 0);
    if (snd_done) done_seen++;
    if (snd_fail) begin fail_seen++; last_code = fail_code; end
    if (rcv_done) rdone_seen++;
    if (rcv_err) rerr_seen++;
  end

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_q();
    while (exp_tx.size() != 0) @(negedge clk);
  endtask

  task automatic rx_byte(input logic [7:0] b);
    @(negedge clk); urx_valid = 1'b1; urx_data = b;
    @(negedge clk); urx_valid = 1'b0;
  endtask

  task automatic start_send(input logic [7:0] len);
    @(negedge clk); snd_len = len; snd_start = 1'b1;
    @(negedge clk); snd_start = 1'b0;
  endtask

  // expected stuffed frame for sbuf[0..len-1] with closing pair and XOR byte
  task automatic push_frame(input int len);
    logic [7:0] x = '0;
    for (int i = 0; i < len; i++) begin
      exp_tx.push_back(sbuf[i]); x ^= sbuf[i];
      if (sbuf[i] == C_DLE) begin exp_tx.push_back(C_DLE); x ^= C_DLE; end
    end
    exp_tx.push_back(C_DLE); exp_tx.push_back(C_ETX);
    x ^= C_DLE ^ C_ETX;
    exp_tx.push_back(x);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int d0, t0, t1;
    wait_n(3); rst_n = 1'b1; wait_n(1);
    check(!utx_valid && !busy && !rcv_valid, "R1", "reset idle", busy, 0);

    // active good, embedded DLE, stalled UART
    sbuf[0] = 8'h41; sbuf[1] = C_DLE; sbuf[2] = 8'h42;
    utx_ready = 1'b0; exp_tx.push_back(C_STX); d0 = done_seen;
    start_send(3);
    for (int i = 0; i < 4; i++) begin
      check(utx_valid && utx_data == C_STX, "R13", "stall hold", utx_data, C_STX);
      @(negedge clk);
    end
    utx_ready = 1'b1; wait_q(); t0 = tx_seen; wait_n(5);
    check(tx_seen == t0, "R1", "no payload before DLE", tx_seen, t0);
    push_frame(3); rx_byte(C_DLE); wait_q();
    rx_byte(C_DLE); wait_n(2);
    check(done_seen == d0 + 1, "R5", "done after final DLE", done_seen, d0 + 1);
    check(exp_tx.size() == 0, "R3", "frame complete", exp_tx.size(), 0);

    // empty payload: DLE ETX 0x13
    exp_tx.push_back(C_STX); start_send(0); wait_q();
    push_frame(0); rx_byte(C_DLE); wait_q(); rx_byte(C_DLE); wait_n(2);
    check(done_seen == d0 + 2, "R2", "empty payload done", done_seen, d0 + 2);

    // connection retries: timeout, NAK, stray byte
    sbuf[0] = 8'h07; d0 = fail_seen;
    exp_tx.push_back(C_STX); start_send(1); wait_q();
    exp_tx.push_back(C_STX); wait_q();
    exp_tx.push_back(C_STX); rx_byte(C_NAK); wait_q();
    rx_byte(8'h55); wait_n(40);
    check(fail_seen == d0 + 1, "R4", "conn fail", fail_seen, d0 + 1);
    check(last_code == 2'd1, "R4", "conn fail code", last_code, 1);

    // block retries: NAK then silence
    d0 = fail_seen;
    exp_tx.push_back(C_STX); start_send(1); wait_q();
    push_frame(1); rx_byte(C_DLE); wait_q();
    exp_tx.push_back(C_STX); rx_byte(C_NAK); wait_q();
    push_frame(1); rx_byte(C_DLE); wait_q(); wait_n(40);
    check(fail_seen == d0 + 1, "R5", "block fail", fail_seen, d0 + 1);
    check(last_code == 2'd2, "R5", "block fail code", last_code, 2);

    // default acknowledge window and default connection retries
    cfg_ack = 16'd0; cfg_conn = 4'd0; d0 = fail_seen;
    exp_tx.push_back(C_STX); start_send(1); wait_q(); t0 = cyc;
    exp_tx.push_back(C_STX); wait_q(); t1 = cyc;
    check(t1 - t0 >= 498 && t1 - t0 <= 506, "R12", "default ack window", t1 - t0, 500);
    exp_tx.push_back(C_STX); wait_q(); exp_tx.push_back(C_STX); wait_q(); wait_n(510);
    check(fail_seen == d0 + 1 && last_code == 2'd1, "R12", "default retries", fail_seen, d0 + 1);

    // slowed tick doubles the window
    cfg_ack = 16'd20; cfg_conn = 4'd1; tick_div = 2; d0 = fail_seen;
    exp_tx.push_back(C_STX); start_send(1); wait_q(); t0 = cyc;
    exp_tx.push_back(C_STX); wait_q(); t1 = cyc; wait_n(60);
    check(t1 - t0 >= 38 && t1 - t0 <= 46, "R12", "tick prescaled window", t1 - t0, 40);
    check(fail_seen == d0 + 1, "R4", "single retry fail", fail_seen, d0 + 1);
    tick_div = 1; cfg_ack = 16'd30;

    // passive good message with doubled DLE
    d0 = rdone_seen;
    exp_tx.push_back(C_DLE); rx_byte(C_STX); wait_q();
    exp_rx.push_back(8'h31); exp_rx.push_back(C_DLE); exp_rx.push_back(8'h32);
    exp_tx.push_back(C_DLE);
    rx_byte(8'h31); rx_byte(C_DLE); rx_byte(C_DLE); rx_byte(8'h32);
    rx_byte(C_DLE); rx_byte(C_ETX); rx_byte(8'h31 ^ 8'h32 ^ C_DLE ^ C_ETX);
    wait_q(); wait_n(2);
    check(rdone_seen == d0 + 1, "R7", "rx good done", rdone_seen, d0 + 1);
    check(exp_rx.size() == 0, "R6", "rx payload complete", exp_rx.size(), 0);

    // passive bad check byte
    d0 = rerr_seen;
    exp_tx.push_back(C_DLE); rx_byte(C_STX); wait_q();
    exp_rx.push_back(8'h05); exp_tx.push_back(C_NAK);
    rx_byte(8'h05); rx_byte(C_DLE); rx_byte(C_ETX); rx_byte(8'h17);
    wait_q(); wait_n(2);
    check(rerr_seen == d0 + 1, "R7", "bad bcc err", rerr_seen, d0 + 1);

    // rejections and silent NAK
    exp_tx.push_back(C_NAK); rx_byte(8'h41); wait_q();
    rcv_en = 1'b0; exp_tx.push_back(C_NAK); rx_byte(C_STX); wait_q(); rcv_en = 1'b1;
    t0 = tx_seen; rx_byte(C_NAK); wait_n(10);
    check(tx_seen == t0 && !busy, "R8", "no reply to NAK", tx_seen, t0);
    check(exp_tx.size() == 0, "R8", "rejects answered", exp_tx.size(), 0);

    // character gap timeout
    d0 = rerr_seen;
    exp_tx.push_back(C_DLE); rx_byte(C_STX); wait_q();
    exp_rx.push_back(8'h01); exp_tx.push_back(C_NAK); rx_byte(8'h01); wait_n(30);
    check(rerr_seen == d0 + 1 && exp_tx.size() == 0, "R9", "char timeout", rerr_seen, d0 + 1);

    // whole-message timeout with a slow but steady stream
    cfg_blk = 16'd45; cfg_char = 16'd25; d0 = rerr_seen;
    exp_tx.push_back(C_DLE); rx_byte(C_STX); wait_q(); t0 = cyc;
    for (int i = 1; i <= 4; i++) exp_rx.push_back(8'(i));
    exp_tx.push_back(C_NAK);
    for (int i = 1; i <= 4; i++) begin wait_n(8); rx_byte(8'(i)); end
    wait_q(); t1 = cyc;
    check(t1 - t0 >= 40 && t1 - t0 <= 58, "R10", "block timeout time", t1 - t0, 46);
    check(rerr_seen == d0 + 1, "R10", "block timeout err", rerr_seen, d0 + 1);
    cfg_blk = 16'd0; cfg_char = 16'd20;

    // overlong message
    d0 = rerr_seen;
    exp_tx.push_back(C_DLE); rx_byte(C_STX); wait_q();
    for (int i = 0; i < 255; i++) begin
      exp_rx.push_back(8'h20 + 8'(i % 64)); rx_byte(8'h20 + 8'(i % 64));
    end
    exp_tx.push_back(C_NAK); rx_byte(8'h41); wait_q(); wait_n(2);
    check(rerr_seen == d0 + 1, "R11", "overlong err", rerr_seen, d0 + 1);
    check(exp_rx.size() == 0, "R11", "255 delivered", exp_rx.size(), 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule